// File: doc/BRIEF.md
# Square Tone and Noise Channel Mixer

This block is the pitch and noise core of a three-voice programmable sound generator. Each voice has a 12-bit period divider that produces a square wave. A shared noise source combines a 5-bit period divider with a 17-bit linear feedback shift register. For every voice the block decides whether the voice is audible in the current cycle (a 1-bit gate) and which 4-bit loudness step applies (a level). The level is either a fixed value from the voice's amplitude field or the level that an external envelope generator currently supplies.

All dividers advance on a common strobe that fires once every 8 input clocks. A free-running 4-bit prescaler produces this strobe. The same prescaler also gives the envelope generator its own strobe once every 16 clocks. The register fields come straight from a bus-side register bank and may change at any time. A period change takes effect on the next divider step and does not restart the counter. A logarithmic volume stage downstream consumes the gate and the level. Summing and sample-rate conversion also happen downstream.

Top module: `psg_tone_mixer`

## Requirements
- R1: Tone and noise dividers change state only on the clock edge at which the prescaler reads 7 modulo 8. The first such edge is the 8th rising edge after reset is released.
- R2: The tone period of voice c is `tone_period_i[12c+11:12c]`. A nonzero period P toggles the voice's square wave every 8·P clocks. A period of 0 behaves as 1.
- R3: On a divider step the counter is incremented. If the incremented value is greater than or equal to the effective period, the counter returns to 0 and the square wave toggles. A period lowered below the current count therefore wraps on the next step without a reset.
- R4: The noise period is `noise_period_i` (5 bits) and 0 behaves as 1. The noise counter toggles an internal noise bit by the same rule as R3.
- R5: The 17-bit noise register holds 1 after reset. It shifts right only on a step where the noise bit toggles from 0 to 1, and bit0 XOR bit3 enters at bit 16. Its bit 0 is the noise value.
- R6: `mix_off_i[c]` set masks the tone of voice c, and `mix_off_i[3+c]` set masks the noise of voice c. The gate is (square OR tone mask) AND (noise value OR noise mask).
- R7: Voice c's amplitude field is `amp_i[5c+4:5c]`. With bit 4 clear the level is bits 3:0. With bit 4 set the level is `env_level_i`.
- R8: Gate and level are registered and are updated together one clock after the state and inputs they are computed from. During reset they read 0.
- R9: `env_step_o` is high for one clock in every 16, and it is first high after the 15th edge following reset. Every envelope strobe coincides with a divider step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_period_i | input | 36 | Three 12-bit tone periods, voice c at bits 12c+11:12c |
| noise_period_i | input | 5 | Noise period |
| mix_off_i | input | 6 | Bits 2:0 mask tone, bits 5:3 mask noise, per voice |
| amp_i | input | 15 | Three 5-bit amplitude fields, bit 4 selects the envelope |
| env_level_i | input | 4 | Current envelope level |
| gate_o | output | 3 | Per-voice audible gate |
| level_o | output | 12 | Per-voice 4-bit level, voice c at bits 4c+3:4c |
| env_step_o | output | 1 | One-clock envelope strobe every 16 clocks |

## Verification
Assertions check the following on every cycle: divider state holds between strobes, counters stay below the period that was in force at their last step, the noise register is never zero and moves only on a rising noise toggle, fully masked voices gate open, and the outputs are cleared by reset. Only the bench's scenarios can show the exact toggle spacing for a given period. They also show the wrap after a period is lowered, the order of the noise sequence and the arrival time of the first strobe after reset. The bench's reference model tracks every divider, the noise register and the prescaler, and compares the gate, level and envelope strobe on every clock.

// File: rtl/psg_mix_pkg.sv
package psg_mix_pkg;

    localparam int NUM_CH_DEF    = 3;
    localparam int TONE_W_DEF    = 12;
    localparam int NOISE_W_DEF   = 5;
    localparam int LEVEL_W_DEF   = 4;
    localparam int LFSR_W_DEF    = 17;
    localparam int LFSR_TAP_DEF  = 3;
    localparam int STEP_LOG2_DEF = 3;
    localparam int ENV_LOG2_DEF  = 4;

    // per-voice masking pair taken from the mixer control field
    typedef struct packed {
        logic tone_off;
        logic noise_off;
    } chan_mask_t;

    // where a voice takes its loudness from
    typedef enum logic {
        LVL_FIXED    = 1'b0,
        LVL_ENVELOPE = 1'b1
    } level_src_e;

endpackage

// File: rtl/psg_prescaler.sv
module psg_prescaler #(
    parameter int STEP_LOG2 = psg_mix_pkg::STEP_LOG2_DEF,
    parameter int ENV_LOG2  = psg_mix_pkg::ENV_LOG2_DEF
) (
    input  logic clk,
    input  logic rst,
    output logic step_o,
    output logic env_step_o
);

    logic [ENV_LOG2-1:0] tick_q;

    always_ff @(posedge clk) begin
        if (rst) tick_q <= '0;
        else     tick_q <= tick_q + 1'b1;
    end

    assign step_o     = &tick_q[STEP_LOG2-1:0];
    assign env_step_o = &tick_q;

    // a divider strobe is never two clocks long
    assert_step_single_R1: assert property (@(posedge clk) disable iff (rst)
        step_o |=> !step_o);

    // envelope strobe is followed by a quiet clock as well
    assert_env_single_R9: assert property (@(posedge clk) disable iff (rst)
        env_step_o |=> !env_step_o);

endmodule

// File: rtl/psg_period_div.sv
module psg_period_div #(
    parameter int W = psg_mix_pkg::TONE_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic [W-1:0] period_i,
    output logic         sq_o
);

    logic [W-1:0] cnt_q;
    logic         sq_q;
    logic [W-1:0] eff_period;
    logic [W:0]   cnt_inc;
    logic         wrap;

    assign eff_period = (period_i == '0) ? {{(W-1){1'b0}}, 1'b1} : period_i;
    assign cnt_inc    = {1'b0, cnt_q} + 1'b1;
    assign wrap       = (cnt_inc >= {1'b0, eff_period});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sq_q  <= 1'b0;
        end else if (step_i) begin
            if (wrap) begin
                cnt_q <= '0;
                sq_q  <= ~sq_q;
            end else begin
                cnt_q <= cnt_inc[W-1:0];
            end
        end
    end

    assign sq_o = sq_q;

    // nothing moves between prescaler strobes
    assert_hold_between_steps_R1: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> ($stable(cnt_q) && $stable(sq_q)));

    // after any step the count is below the period that step used
    assert_count_below_period_R3: assert property (@(posedge clk) disable iff (rst)
        step_i |=> (cnt_q < $past(eff_period)));

endmodule

// File: rtl/psg_noise_gen.sv
module psg_noise_gen #(
    parameter int NOISE_W  = psg_mix_pkg::NOISE_W_DEF,
    parameter int LFSR_W   = psg_mix_pkg::LFSR_W_DEF,
    parameter int LFSR_TAP = psg_mix_pkg::LFSR_TAP_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_i,
    input  logic [NOISE_W-1:0] period_i,
    output logic               noise_o
);

    logic [NOISE_W-1:0] cnt_q;
    logic               nbit_q;
    logic [LFSR_W-1:0]  lfsr_q;
    logic [NOISE_W-1:0] eff_period;
    logic [NOISE_W:0]   cnt_inc;
    logic               wrap;
    logic               advance;
    logic               feedback;

    assign eff_period = (period_i == '0) ? {{(NOISE_W-1){1'b0}}, 1'b1} : period_i;
    assign cnt_inc    = {1'b0, cnt_q} + 1'b1;
    assign wrap       = step_i && (cnt_inc >= {1'b0, eff_period});
    // shift only when the noise bit is about to become 1
    assign advance    = wrap && !nbit_q;
    assign feedback   = lfsr_q[0] ^ lfsr_q[LFSR_TAP];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            nbit_q <= 1'b0;
        end else if (step_i) begin
            if (wrap) begin
                cnt_q  <= '0;
                nbit_q <= ~nbit_q;
            end else begin
                cnt_q <= cnt_inc[NOISE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          lfsr_q <= {{(LFSR_W-1){1'b0}}, 1'b1};
        else if (advance) lfsr_q <= {feedback, lfsr_q[LFSR_W-1:1]};
    end

    assign noise_o = lfsr_q[0];

    // the register can never fall into the all-zero lock-up state
    assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    // the register moves only together with a rising noise toggle
    assert_lfsr_moves_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(lfsr_q) |-> $rose(nbit_q));

    // noise counter stays inside its period after each step
    assert_noise_count_R4: assert property (@(posedge clk) disable iff (rst)
        step_i |=> (cnt_q < $past(eff_period)));

endmodule

// File: rtl/psg_chan_mix.sv
module psg_chan_mix
    import psg_mix_pkg::*;
#(
    parameter int LEVEL_W = psg_mix_pkg::LEVEL_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tone_i,
    input  logic               noise_i,
    input  chan_mask_t         mask_i,
    input  logic [LEVEL_W:0]   amp_i,
    input  logic [LEVEL_W-1:0] env_level_i,
    output logic               gate_o,
    output logic [LEVEL_W-1:0] level_o
);

    level_src_e         src;
    logic               gate_d;
    logic [LEVEL_W-1:0] level_d;

    assign src = level_src_e'(amp_i[LEVEL_W]);

    always_comb begin
        gate_d = (tone_i | mask_i.tone_off) & (noise_i | mask_i.noise_off);
        unique case (src)
            LVL_ENVELOPE: level_d = env_level_i;
            default:      level_d = amp_i[LEVEL_W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_o  <= 1'b0;
            level_o <= '0;
        end else begin
            gate_o  <= gate_d;
            level_o <= level_d;
        end
    end

    // a voice with both sources masked is always audible
    assert_masked_open_R6: assert property (@(posedge clk) disable iff (rst)
        (mask_i.tone_off && mask_i.noise_off) |=> gate_o);

    // envelope-driven voices follow the envelope one clock later
    assert_env_follow_R7: assert property (@(posedge clk) disable iff (rst)
        amp_i[LEVEL_W] |=> (level_o == $past(env_level_i)));

endmodule

// File: rtl/psg_tone_mixer.sv
module psg_tone_mixer
    import psg_mix_pkg::*;
#(
    parameter int NUM_CH    = psg_mix_pkg::NUM_CH_DEF,
    parameter int TONE_W    = psg_mix_pkg::TONE_W_DEF,
    parameter int NOISE_W   = psg_mix_pkg::NOISE_W_DEF,
    parameter int LEVEL_W   = psg_mix_pkg::LEVEL_W_DEF,
    parameter int LFSR_W    = psg_mix_pkg::LFSR_W_DEF,
    parameter int LFSR_TAP  = psg_mix_pkg::LFSR_TAP_DEF,
    parameter int STEP_LOG2 = psg_mix_pkg::STEP_LOG2_DEF,
    parameter int ENV_LOG2  = psg_mix_pkg::ENV_LOG2_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CH*TONE_W-1:0]    tone_period_i,
    input  logic [NOISE_W-1:0]          noise_period_i,
    input  logic [2*NUM_CH-1:0]         mix_off_i,
    input  logic [NUM_CH*(LEVEL_W+1)-1:0] amp_i,
    input  logic [LEVEL_W-1:0]          env_level_i,
    output logic [NUM_CH-1:0]           gate_o,
    output logic [NUM_CH*LEVEL_W-1:0]   level_o,
    output logic                        env_step_o
);

    localparam int AMP_W = LEVEL_W + 1;

    logic              div_step;
    logic              noise_bit;
    logic [NUM_CH-1:0] tone_sq;

    psg_prescaler #(
        .STEP_LOG2 (STEP_LOG2),
        .ENV_LOG2  (ENV_LOG2)
    ) u_presc (
        .clk        (clk),
        .rst        (rst),
        .step_o     (div_step),
        .env_step_o (env_step_o)
    );

    psg_noise_gen #(
        .NOISE_W  (NOISE_W),
        .LFSR_W   (LFSR_W),
        .LFSR_TAP (LFSR_TAP)
    ) u_noise (
        .clk      (clk),
        .rst      (rst),
        .step_i   (div_step),
        .period_i (noise_period_i),
        .noise_o  (noise_bit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_voice
        chan_mask_t mask;
        assign mask.tone_off  = mix_off_i[c];
        assign mask.noise_off = mix_off_i[NUM_CH + c];

        psg_period_div #(
            .W (TONE_W)
        ) u_div (
            .clk      (clk),
            .rst      (rst),
            .step_i   (div_step),
            .period_i (tone_period_i[c*TONE_W +: TONE_W]),
            .sq_o     (tone_sq[c])
        );

        psg_chan_mix #(
            .LEVEL_W (LEVEL_W)
        ) u_mix (
            .clk         (clk),
            .rst         (rst),
            .tone_i      (tone_sq[c]),
            .noise_i     (noise_bit),
            .mask_i      (mask),
            .amp_i       (amp_i[c*AMP_W +: AMP_W]),
            .env_level_i (env_level_i),
            .gate_o      (gate_o[c]),
            .level_o     (level_o[c*LEVEL_W +: LEVEL_W])
        );
    end

    // reset clears every registered output on the following clock
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (gate_o == '0 && level_o == '0));

    // each envelope strobe lands on a divider step
    assert_env_on_step_R9: assert property (@(posedge clk) disable iff (rst)
        env_step_o |-> div_step);

endmodule

// File: tb/psg_tone_mixer_tb.sv
module psg_tone_mixer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [35:0] tone_period = '0;
    logic [4:0]  noise_period = '0;
    logic [5:0]  mix_off = 6'h3F;
    logic [14:0] amp = '0;
    logic [3:0]  env_level = '0;
    logic [2:0]  gate;
    logic [11:0] level;
    logic        env_step;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string cur_req = "R8";

    always #10 clk = ~clk;   // 50 MHz

    psg_tone_mixer u_dut (
        .clk            (clk),
        .rst            (rst),
        .tone_period_i  (tone_period),
        .noise_period_i (noise_period),
        .mix_off_i      (mix_off),
        .amp_i          (amp),
        .env_level_i    (env_level),
        .gate_o         (gate),
        .level_o        (level),
        .env_step_o     (env_step)
    );

    // ---------------- behavioural reference model ----------------
    int   m_tcnt [3];
    int   m_tbit [3];
    int   m_ncnt, m_nbit, m_lfsr, m_tick;
    logic [2:0]  exp_gate;
    logic [11:0] exp_level;
    bit   model_on = 0;

    function automatic int eff(int p);
        return (p == 0) ? 1 : p;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_tcnt[i]) begin m_tcnt[i] = 0; m_tbit[i] = 0; end
            m_ncnt = 0; m_nbit = 0; m_lfsr = 1; m_tick = 0;
            exp_gate = '0; exp_level = '0;
            model_on = 1;
        end else begin
            for (int c = 0; c < 3; c++) begin
                int a;
                a = (amp >> (5*c)) & 31;
                exp_gate[c] = ((m_tbit[c] != 0) || mix_off[c]) &&
                              (((m_lfsr & 1) != 0) || mix_off[3+c]);
                exp_level[4*c +: 4] = (a >= 16) ? env_level : 4'(a & 15);
            end
            if ((m_tick % 8) == 7) begin
                for (int c = 0; c < 3; c++) begin
                    int p;
                    p = (tone_period >> (12*c)) & 12'hFFF;
                    if (m_tcnt[c] + 1 >= eff(p)) begin
                        m_tcnt[c] = 0; m_tbit[c] ^= 1;
                    end else m_tcnt[c] += 1;
                end
                if (m_ncnt + 1 >= eff(noise_period)) begin
                    m_ncnt = 0; m_nbit ^= 1;
                    if (m_nbit == 1) begin
                        int fb;
                        fb = (m_lfsr ^ (m_lfsr >> 3)) & 1;
                        m_lfsr = (m_lfsr >> 1) | (fb << 16);
                    end
                end else m_ncnt += 1;
            end
            m_tick = (m_tick + 1) % 16;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            checks++;
            if (gate !== exp_gate || level !== exp_level ||
                env_step !== (m_tick == 15)) begin
                fails++;
                $display("FAIL %s model: gate=%b level=%h env=%b expected gate=%b level=%h env=%b",
                         cur_req, gate, level, env_step, exp_gate, exp_level, m_tick == 15);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(string req, int actual, int expected, string what);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    task automatic edge_drive();
        @(posedge clk); #2;
    endtask

    task automatic do_reset();
        edge_drive(); rst = 1'b1;
        edge_drive(); edge_drive(); rst = 1'b0;
    endtask

    // clocks between two consecutive changes of gate bit ch
    task automatic measure(int ch, output int span);
        logic prev;
        int n;
        @(negedge clk); prev = gate[ch];
        while (gate[ch] == prev) @(negedge clk);
        prev = gate[ch]; n = 0;
        while (gate[ch] == prev) begin @(negedge clk); n++; end
        span = n;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        int span;
        // reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", gate, 0, "gate in reset");
        check("R8", level, 0, "level in reset");

        // first strobe timing: voice 0 tone only, period 1
        cur_req = "R1";
        tone_period = 36'h000_000_001;
        mix_off = 6'b111_110;
        amp = {5'd0, 5'd0, 5'd9};
        edge_drive(); rst = 1'b0;
        repeat (8) @(posedge clk);
        @(negedge clk); check("R1", gate[0], 0, "gate after 8th edge");
        @(negedge clk); check("R1", gate[0], 1, "gate after 9th edge");
        check("R7", level[3:0], 9, "fixed level");
        repeat (5) @(negedge clk);
        check("R9", env_step, 0, "env strobe after 14th edge");
        @(negedge clk); check("R9", env_step, 1, "env strobe after 15th edge");
        @(negedge clk); check("R9", env_step, 0, "env strobe after 16th edge");

        // toggle spacing
        cur_req = "R2";
        tone_period = {12'd0, 12'd5, 12'd3};
        mix_off = 6'b111_000;
        measure(0, span); check("R2", span, 24, "period 3 half-wave");
        measure(1, span); check("R2", span, 40, "period 5 half-wave");
        measure(2, span); check("R2", span, 8, "period 0 half-wave");

        // lowering the period below the count
        cur_req = "R3";
        edge_drive(); tone_period = {12'd7, 12'd9, 12'd200};
        repeat (900) @(posedge clk); #2;
        tone_period = {12'd7, 12'd9, 12'd4};
        repeat (200) @(posedge clk);

        // noise only on voice 0, exact first steps after reset
        cur_req = "R5";
        noise_period = 5'd0;
        mix_off = 6'b110_111;
        do_reset();
        repeat (8) @(posedge clk);
        @(negedge clk); check("R5", gate[0], 1, "seed value visible");
        @(negedge clk); check("R5", gate[0], 0, "after first rising toggle");
        repeat (2000) @(posedge clk);

        cur_req = "R4";
        edge_drive(); noise_period = 5'd31;
        repeat (3000) @(posedge clk);
        edge_drive(); noise_period = 5'd1;
        repeat (1500) @(posedge clk);

        // mixing patterns
        cur_req = "R6";
        edge_drive(); mix_off = 6'h3F;
        edge_drive();
        @(negedge clk); check("R6", gate, 7, "all masked gate open");
        edge_drive(); mix_off = 6'h00;
        edge_drive(); mix_off = 6'b011_101;
        for (int k = 0; k < 80; k++) begin
            edge_drive();
            mix_off = 6'($urandom);
            tone_period = {12'($urandom % 40), 12'($urandom % 40), 12'($urandom % 40)};
            noise_period = 5'($urandom);
            repeat (37) @(posedge clk);
        end

        // level source selection
        cur_req = "R7";
        edge_drive(); amp = {5'h0C, 5'h10, 5'h1F}; env_level = 4'd7;
        @(posedge clk); @(negedge clk);
        check("R7", level[7:4], 7, "envelope level");
        check("R7", level[11:8], 12, "fixed level");
        for (int k = 0; k < 200; k++) begin
            edge_drive();
            env_level = 4'($urandom);
            if (k % 16 == 0) amp = 15'($urandom);
        end
        edge_drive(); env_level = 4'd3;
        @(posedge clk); @(negedge clk);
        check("R7", level[3:0], (amp[4] ? 3 : amp[3:0]), "voice 0 level");

        // reset in the middle of activity
        cur_req = "R8";
        edge_drive(); rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R8", gate, 0, "gate cleared");
        check("R8", level, 0, "level cleared");
        edge_drive(); rst = 1'b0;
        repeat (100) @(posedge clk);
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule